// File: doc/BRIEF.md
# Sector Transfer Engine Between Word Memory and a 16-bit Device Port

This block copies one 512-byte disk sector between system memory and the data register of an attached storage device. Each step on the device side is a programmed I/O cycle. The memory side is a 32-bit single-beat master. The device side is a 16-bit request/done port that feeds a shared PIO cycle sequencer. The host stores a memory start address. It then issues a command strobe that carries a "transfer sector" flag and a direction flag.

In the to-device direction, the engine reads one 32-bit word from memory and sends it as two 16-bit device writes, low half first. In the from-device direction, it collects two 16-bit device reads and stores them as one 32-bit memory write, with the first read in the low half. The memory pointer steps by four bytes per word. The host sees a busy flag for the whole sector.

Top module: `sector_dma`

## Requirements
- R1: After reset, `busy`, `mem_req` and `pio_req` are 0 and `start_addr` reads 0.
- R2: `start_addr` always reads the last value written on `addr_wdata` with bits 1..0 forced to 0, and the transfer starts from that aligned address.
- R3: A transfer starts only on a cycle with `cmd_we`=1, `cmd_xfer`=1 and the engine idle. A command without `cmd_xfer`, or any command while busy, has no effect. An address write while busy changes `start_addr` but not the addresses used by the running transfer.
- R4: `busy` is 1 from the cycle after the starting command until the final handshake, and it is 0 in the cycle after that handshake.
- R5: One sector is exactly 256 device cycles. Every device cycle has `pio_sel`=5'b01000 (bit 4 = control-block select 0, bit 3 = command-block select 1, bits 2..0 = register 0). `pio_write` equals the `cmd_dir` value latched at the start (1 = to device).
- R6: One sector is exactly 128 memory accesses, at addresses start+4k for k = 0..127 in increasing order.
- R7: In the to-device direction, every memory access is a read (`mem_we`=0). Device write 2k carries bits 15..0, and write 2k+1 carries bits 31..16, of the word read at start+4k.
- R8: In the from-device direction, every memory access is a write (`mem_we`=1). Word k is {read 2k+1, read 2k}.
- R9: `mem_req` and `pio_req` are never high together. No device cycle is requested before the memory access it depends on has been acknowledged, and the reverse also holds.
- R10: A raised `mem_req` or `pio_req` stays high, with stable address, direction and data, until its `mem_ack` or `pio_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_we | input | 1 | Host write strobe for the start address |
| addr_wdata | input | 32 | Start address value |
| start_addr | output | 32 | Stored start address, low two bits zero |
| cmd_we | input | 1 | Host command strobe |
| cmd_xfer | input | 1 | Command flag: transfer one sector |
| cmd_dir | input | 1 | Command flag: 1 = memory to device, 0 = device to memory |
| busy | output | 1 | Sector transfer in progress |
| mem_req | output | 1 | Memory access request, held until acknowledge |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| pio_req | output | 1 | Device cycle request, held until done |
| pio_write | output | 1 | 1 = device write cycle, 0 = device read cycle |
| pio_sel | output | 5 | Device register select {cs1, cs0, a2, a1, a0} |
| pio_wdata | output | 16 | Device write data |
| pio_rdata | input | 16 | Device read data, valid with pio_done |
| pio_done | input | 1 | Device cycle complete |

## Verification
The first request and `busy` are due one clock edge after the edge that takes the command. Every later request, or its withdrawal, is due one edge after the handshake that ends the previous one. `busy` falls one edge after the final handshake. The bench drives the acknowledges and changes inputs on falling edges, and it reads outputs there. Each handshake is therefore scored on the falling edge where the bench raises the acknowledge, before the rising edge that consumes it. The bench compares the exact cycle numbers of the last handshake and the fall of `busy`. Latencies from zero to three cycles on each side are swept, so back-to-back handshakes and long waits both occur.

// File: rtl/sector_dma.sv
module sector_dma #(
  parameter int AW           = 32,
  parameter int MW           = 32,
  parameter int PW           = 16,
  parameter int SECTOR_BYTES = 512,
  parameter int SW           = 5,
  parameter logic [SW-1:0] DATA_SEL = 5'b01000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_wdata,
  output logic [AW-1:0] start_addr,
  input  logic          cmd_we,
  input  logic          cmd_xfer,
  input  logic          cmd_dir,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [MW-1:0] mem_wdata,
  input  logic [MW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          pio_req,
  output logic          pio_write,
  output logic [SW-1:0] pio_sel,
  output logic [PW-1:0] pio_wdata,
  input  logic [PW-1:0] pio_rdata,
  input  logic          pio_done
);
  localparam int BPW   = MW / 8;
  localparam int WORDS = SECTOR_BYTES / BPW;
  localparam int HALVES = MW / PW;
  localparam int WCW   = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int HCW   = (HALVES > 1) ? $clog2(HALVES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_MEM_RD, S_PIO, S_MEM_WR} st_t;

  st_t            st_q;
  logic           dir_q;
  logic [AW-1:0]  base_q;
  logic [AW-1:0]  ptr_q;
  logic [MW-1:0]  buf_q;
  logic [WCW-1:0] wcnt_q;
  logic [HCW-1:0] half_q;

  wire go        = cmd_we && cmd_xfer && (st_q == S_IDLE);
  wire last_half = (half_q == HCW'(HALVES - 1));
  wire last_word = (wcnt_q == WCW'(WORDS - 1));

  assign start_addr = base_q & ~AW'(BPW - 1);
  assign busy       = (st_q != S_IDLE);
  assign mem_req    = (st_q == S_MEM_RD) || (st_q == S_MEM_WR);
  assign mem_we     = (st_q == S_MEM_WR);
  assign mem_addr   = ptr_q;
  assign mem_wdata  = buf_q;
  assign pio_req    = (st_q == S_PIO);
  assign pio_write  = dir_q;
  assign pio_sel    = DATA_SEL;
  assign pio_wdata  = buf_q[half_q*PW +: PW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      dir_q  <= 1'b0;
      base_q <= '0;
      ptr_q  <= '0;
      buf_q  <= '0;
      wcnt_q <= '0;
      half_q <= '0;
    end else begin
      if (addr_we) base_q <= addr_wdata;
      unique case (st_q)
        S_IDLE: if (go) begin
          dir_q  <= cmd_dir;
          ptr_q  <= start_addr;
          wcnt_q <= '0;
          half_q <= '0;
          st_q   <= cmd_dir ? S_MEM_RD : S_PIO;
        end
        S_MEM_RD: if (mem_ack) begin
          buf_q  <= mem_rdata;
          half_q <= '0;
          st_q   <= S_PIO;
        end
        S_PIO: if (pio_done) begin
          if (!dir_q) buf_q[half_q*PW +: PW] <= pio_rdata;
          if (last_half) begin
            half_q <= '0;
            if (dir_q) begin
              ptr_q  <= ptr_q + AW'(BPW);
              wcnt_q <= wcnt_q + 1'b1;
              st_q   <= last_word ? S_IDLE : S_MEM_RD;
            end else begin
              st_q <= S_MEM_WR;
            end
          end else begin
            half_q <= half_q + 1'b1;
          end
        end
        S_MEM_WR: if (mem_ack) begin
          ptr_q  <= ptr_q + AW'(BPW);
          wcnt_q <= wcnt_q + 1'b1;
          st_q   <= last_word ? S_IDLE : S_PIO;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sector_dma_chk.sv
module sector_dma_chk #(
  parameter int AW = 32,
  parameter int MW = 32,
  parameter int PW = 16,
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] start_addr,
  input logic          cmd_we,
  input logic          cmd_xfer,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [MW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          pio_req,
  input logic          pio_write,
  input logic [SW-1:0] pio_sel,
  input logic [PW-1:0] pio_wdata,
  input logic          pio_done
);
  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_addr[1:0] == 2'b00);

  p_no_spurious_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_we && cmd_xfer)) |=> !busy);

  p_req_implies_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || pio_req) |-> busy);

  p_data_reg_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pio_req |-> (pio_sel == 5'b01000));

  p_dir_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pio_write));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && pio_req));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_pio_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pio_req && !pio_done) |=>
      (pio_req && $stable(pio_write) && $stable(pio_wdata)));
endmodule

bind sector_dma sector_dma_chk #(.AW(AW), .MW(MW), .PW(PW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
  .cmd_we(cmd_we), .cmd_xfer(cmd_xfer), .busy(busy),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .pio_req(pio_req), .pio_write(pio_write), .pio_sel(pio_sel),
  .pio_wdata(pio_wdata), .pio_done(pio_done)
);

// File: tb/sector_dma_tb.sv
`timescale 1ns/1ps
module sector_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_we = 1'b0;
  logic [31:0] addr_wdata = '0;
  logic [31:0] start_addr;
  logic        cmd_we = 1'b0, cmd_xfer = 1'b0, cmd_dir = 1'b0;
  logic        busy;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        pio_req, pio_write;
  logic [4:0]  pio_sel;
  logic [15:0] pio_wdata;
  logic [15:0] pio_rdata = '0;
  logic        pio_done = 1'b0;

  always #2.5 clk = ~clk;

  sector_dma u_dut (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .start_addr(start_addr), .cmd_we(cmd_we), .cmd_xfer(cmd_xfer),
    .cmd_dir(cmd_dir), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .pio_req(pio_req), .pio_write(pio_write),
    .pio_sel(pio_sel), .pio_wdata(pio_wdata), .pio_rdata(pio_rdata),
    .pio_done(pio_done)
  );

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int mem_lat = 0, pio_lat = 0, mem_wait = 0, pio_wait = 0;
  int mem_idx = 0, pio_idx = 0, overlap = 0, last_hs = 0;
  bit cur_dir = 1'b0;
  logic [31:0] cur_start = '0, seed = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ seed;
  endfunction

  function automatic logic [15:0] dev(input int i);
    return 16'(i * 263) ^ seed[15:0];
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && pio_req) overlap++;
      if (mem_req && mem_wait >= mem_lat) begin
        logic [31:0] ea;
        ea = cur_start + 32'(4 * mem_idx);
        mem_ack = 1'b1; mem_wait = 0; last_hs = cyc;
        chk(mem_addr == ea, "R6 address", mem_addr, ea);
        chk(mem_we == !cur_dir, "R7/R8 access kind", 32'(mem_we), 32'(!cur_dir));
        if (cur_dir) mem_rdata = pat(mem_addr);
        else chk(mem_wdata == {dev(2*mem_idx+1), dev(2*mem_idx)}, "R8 packed word",
                 mem_wdata, {dev(2*mem_idx+1), dev(2*mem_idx)});
        mem_idx++;
      end else begin
        mem_ack = 1'b0;
        if (mem_req) mem_wait++;
      end
      if (pio_req && pio_wait >= pio_lat) begin
        logic [31:0] w;
        logic [15:0] eh;
        pio_done = 1'b1; pio_wait = 0; last_hs = cyc;
        chk(pio_sel == 5'b01000, "R5 select", 32'(pio_sel), 32'h8);
        chk(pio_write == cur_dir, "R5 direction", 32'(pio_write), 32'(cur_dir));
        if (cur_dir) begin
          w  = pat(cur_start + 32'(4 * (pio_idx / 2)));
          eh = (pio_idx % 2 == 0) ? w[15:0] : w[31:16];
          chk(pio_wdata == eh, "R7 half order", 32'(pio_wdata), 32'(eh));
        end else pio_rdata = dev(pio_idx);
        pio_idx++;
      end else begin
        pio_done = 1'b0;
        if (pio_req) pio_wait++;
      end
    end
  end

  task automatic set_addr(input logic [31:0] a);
    @(negedge clk); addr_we = 1'b1; addr_wdata = a;
    @(negedge clk); addr_we = 1'b0;
    chk(start_addr == (a & ~32'h3), "R2 readback", start_addr, a & ~32'h3);
  endtask

  task automatic run_xfer(input bit dir, input logic [31:0] a, input int ml, input int pl,
                          input logic [31:0] s, input bit meddle);
    int t;
    set_addr(a);
    mem_lat = ml; pio_lat = pl; seed = s; cur_dir = dir;
    cur_start = a & ~32'h3; mem_idx = 0; pio_idx = 0; overlap = 0;
    mem_wait = 0; pio_wait = 0;
    @(negedge clk); cmd_we = 1'b1; cmd_xfer = 1'b1; cmd_dir = dir;
    @(negedge clk); cmd_we = 1'b0;
    chk(busy == 1'b1, "R4 busy after start", 32'(busy), 1);
    chk((dir ? mem_req : pio_req) == 1'b1, "R3 first request", 32'(dir ? mem_req : pio_req), 1);
    if (meddle) begin
      repeat (30) @(negedge clk);
      cmd_we = 1'b1; cmd_xfer = 1'b1; cmd_dir = !dir;
      addr_we = 1'b1; addr_wdata = 32'h0000_F000;
      @(negedge clk); cmd_we = 1'b0; addr_we = 1'b0;
      chk(start_addr == 32'h0000_F000, "R3 address write while busy", start_addr, 32'h0000_F000);
    end
    t = 0;
    while (busy && t < 6000) begin @(negedge clk); t++; end
    chk(!busy, "R4 busy clears", 32'(busy), 0);
    chk(cyc - last_hs == 1, "R4 busy falls one cycle after last handshake", 32'(cyc - last_hs), 1);
    chk(pio_idx == 256, "R5 device cycle count", 32'(pio_idx), 256);
    chk(mem_idx == 128, "R6 memory access count", 32'(mem_idx), 128);
    chk(overlap == 0, "R9 exclusive requests", 32'(overlap), 0);
    repeat (3) @(negedge clk);
    chk(pio_idx == 256 && mem_idx == 128 && !busy, "R3 no restart", 32'(pio_idx), 256);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !pio_req, "R1 reset outputs", {mem_req, pio_req, busy}, 0);
    chk(start_addr == 32'h0, "R1 reset address", start_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmd_we = 1'b1; cmd_xfer = 1'b0; cmd_dir = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
    repeat (4) begin
      chk(!busy && !mem_req && !pio_req, "R3 command without transfer flag",
          {mem_req, pio_req, busy}, 0);
      @(negedge clk);
    end
    set_addr(32'h1234_5677);
    run_xfer(1'b1, 32'h0000_1000, 0, 0, 32'hA5A5_0F0F, 1'b0);
    run_xfer(1'b0, 32'h0000_2000, 0, 0, 32'h0000_3C3C, 1'b0);
    run_xfer(1'b1, 32'h0000_3006, 2, 1, 32'h1357_9BDF, 1'b0);
    run_xfer(1'b0, 32'h0000_4003, 1, 3, 32'h0000_7E81, 1'b0);
    run_xfer(1'b1, 32'hFFFF_FE00, 3, 0, 32'hDEAD_BEEF, 1'b1);
    run_xfer(1'b0, 32'h8000_0000, 0, 2, 32'h0000_1111, 1'b1);
    run_xfer(1'b1, 32'h0000_0004, 1, 1, 32'h0F0F_F0F0, 1'b0);
    run_xfer(1'b0, 32'h0000_0FFC, 3, 3, 32'h0000_ABCD, 1'b0);
    report();
  end
endmodule